// File: doc/BRIEF.md
# PCI Target Base Address Decoder

This block holds the two base address registers of a PCI target function: one that places a 32-byte window in I/O space and one that places a 32-byte, non-prefetchable window in memory space. The host reaches both through a small configuration port. That port carries a dword index, byte enables, write data and a combinational read-data return. The writable part of each register is the base field in bits 31 to 5. The low five bits are fixed, so a host that writes all ones and reads back learns the window size and type.

During bus traffic the block watches the address-phase signals: the AD bus, the command nibble and a frame strobe. On the first clock of a new frame it compares AD[31:5] against the base of the window that the command selects. A command counts only while its space-enable bit from the external command register is set. A match raises a registered one-cycle hit that asks the bus state machine to claim the cycle with DEVSEL. A second output tells whether the hit was for the memory window. Only a hard reset clears the base fields. No other input of the block touches them.

Top module: `pci_bar_decoder`

## Requirements
- R1: The I/O register lives at dword index 4 (byte offset 10h). Bits 31:5 hold a host-writable base. Bits 4:0 always read 5'b00001 (bit 0 = 1 marks I/O space), and writes to bits 4:0 have no effect.
- R2: The memory register lives at dword index 5 (byte offset 14h). Bits 31:5 hold a host-writable base. Bits 4:0 always read 5'b00000: bit 0 = 0 marks memory space, bits 2:1 = 00 mean 32-bit locatable, and bit 3 = 0 means not prefetchable. Writes to bits 4:0 have no effect.
- R3: After a write of FFFF_FFFFh with all byte enables set, the I/O register reads FFFF_FFE1h and the memory register reads FFFF_FFE0h.
- R4: A write updates only the byte lanes whose enable is set (cfg_be[n] covers cfg_wdata[8n+7:8n]). The other lanes keep their previous value.
- R5: A write to any index other than 4 or 5 changes neither register. A read of any other index returns zero.
- R6: An active-low hard reset clears both base fields to zero.
- R7: An I/O hit occurs when the command is 0010b or 0011b, AD[31:5] equals the I/O base, and cmd_io_en is 1.
- R8: A memory hit occurs when the command is 0110b, 0111b, 1100b or 1110b, AD[31:5] equals the memory base, and cmd_mem_en is 1. dec_mem is 1 with such a hit and 0 with an I/O hit.
- R9: Every other command value never hits, and a window whose enable bit is 0 never hits.
- R10: Decode uses the inputs on the first clock edge at which frame_start is high after being low. dec_hit rises after that edge and lasts exactly one cycle, even if frame_start stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for the indexed dword |
| ad | input | 32 | Address/data bus during the address phase |
| bus_cmd | input | 4 | Bus command in the address phase |
| frame_start | input | 1 | High while a bus transaction is framed |
| cmd_io_en | input | 1 | I/O space enable from the command register |
| cmd_mem_en | input | 1 | Memory space enable from the command register |
| dec_hit | output | 1 | One-cycle request to claim the cycle |
| dec_mem | output | 1 | The hit belongs to the memory window |

## Verification
The bench writes partial-byte patterns and reads back both registers, to catch a design that ignores byte lanes (whole words would change) or that lets the low bits take writes (the size probe would return the wrong type bits). It sends each command code with the enables in all four combinations and with addresses that differ only in bit 5 or only in bits 4:0. A decoder that compares the wrong field, mixes up the enables or accepts a stray command would then raise a hit that is not expected, or miss one that is. It holds the frame strobe high for several cycles, so that a level-sensitive decoder shows up as a repeated hit. It checks that the bases survive writes to neighbouring indices and that a hard reset clears them.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;

    localparam logic [3:0] CMD_IO_RD   = 4'b0010;
    localparam logic [3:0] CMD_IO_WR   = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
    localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
    localparam logic [3:0] CMD_MEM_RDL = 4'b1110;

    typedef struct packed {
        logic frame;
        logic hit;
        logic mem;
    } dec_state_t;

endpackage

// File: rtl/bar_cmd_class.sv
module bar_cmd_class
    import bar_dec_pkg::*;
(
    input  logic [3:0] cmd,
    output logic       is_io,
    output logic       is_mem
);

    always_comb begin
        is_io  = 1'b0;
        is_mem = 1'b0;
        case (cmd)
            CMD_IO_RD, CMD_IO_WR:                            is_io  = 1'b1;
            CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RDM, CMD_MEM_RDL: is_mem = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/bar_reg.sv
module bar_reg #(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 5,
    parameter bit IS_IO    = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_sel,
    input  logic [ADDR_W/8-1:0]        be,
    input  logic [ADDR_W-1:0]          wdata,
    output logic [ADDR_W-WIN_BITS-1:0] base,
    output logic [ADDR_W-1:0]          rd_word
);

    localparam int BASE_W = ADDR_W - WIN_BITS;
    localparam logic [WIN_BITS-1:0] LOW_BITS = WIN_BITS'(IS_IO);

    logic [BASE_W-1:0] base_d, base_q;
    logic              unused_wlow;

    assign unused_wlow = ^wdata[WIN_BITS-1:0];

    always_comb begin
        base_d = base_q;
        if (wr_sel) begin
            for (int b = 0; b < BASE_W; b++) begin
                if (be[(b + WIN_BITS) / 8]) begin
                    base_d[b] = wdata[b + WIN_BITS];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else begin
            base_q <= base_d;
        end
    end

    assign base    = base_q;
    assign rd_word = {base_q, LOW_BITS};

endmodule

// File: rtl/pci_bar_decoder.sv
module pci_bar_decoder
    import bar_dec_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int WIN_BITS    = 5,
    parameter int CFG_AW      = 6,
    parameter int IO_BAR_IDX  = 4,
    parameter int MEM_BAR_IDX = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [ADDR_W/8-1:0] cfg_be,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    output logic [ADDR_W-1:0]   cfg_rdata,
    input  logic [ADDR_W-1:0]   ad,
    input  logic [3:0]          bus_cmd,
    input  logic                frame_start,
    input  logic                cmd_io_en,
    input  logic                cmd_mem_en,
    output logic                dec_hit,
    output logic                dec_mem
);

    localparam int BASE_W = ADDR_W - WIN_BITS;
    localparam int NBAR   = 2;
    localparam int IO_I   = 0;
    localparam int MEM_I  = 1;

    logic [BASE_W-1:0] bar_base [NBAR];
    logic [ADDR_W-1:0] bar_word [NBAR];
    logic [NBAR-1:0]   bar_wr;
    logic              is_io, is_mem;
    logic              unused_adlow;
    dec_state_t        st_d, st_q;

    assign unused_adlow = ^ad[WIN_BITS-1:0];

    assign bar_wr[IO_I]  = cfg_wr && (cfg_addr == CFG_AW'(IO_BAR_IDX));
    assign bar_wr[MEM_I] = cfg_wr && (cfg_addr == CFG_AW'(MEM_BAR_IDX));

    for (genvar g = 0; g < NBAR; g++) begin : g_bar
        bar_reg #(
            .ADDR_W   (ADDR_W),
            .WIN_BITS (WIN_BITS),
            .IS_IO    (g == IO_I)
        ) u_bar (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (bar_wr[g]),
            .be      (cfg_be),
            .wdata   (cfg_wdata),
            .base    (bar_base[g]),
            .rd_word (bar_word[g])
        );
    end

    bar_cmd_class u_cls (
        .cmd    (bus_cmd),
        .is_io  (is_io),
        .is_mem (is_mem)
    );

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == CFG_AW'(IO_BAR_IDX)) begin
            cfg_rdata = bar_word[IO_I];
        end else if (cfg_addr == CFG_AW'(MEM_BAR_IDX)) begin
            cfg_rdata = bar_word[MEM_I];
        end
    end

    always_comb begin
        logic start, io_m, mem_m;
        st_d       = st_q;
        start      = frame_start && !st_q.frame;
        io_m       = start && is_io && cmd_io_en
                     && (ad[ADDR_W-1:WIN_BITS] == bar_base[IO_I]);
        mem_m      = start && is_mem && cmd_mem_en
                     && (ad[ADDR_W-1:WIN_BITS] == bar_base[MEM_I]);
        st_d.frame = frame_start;
        st_d.hit   = io_m || mem_m;
        st_d.mem   = mem_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_hit = st_q.hit;
    assign dec_mem = st_q.mem;

endmodule

// File: rtl/bar_dec_chk.sv
module bar_dec_chk #(
    parameter int CFG_AW  = 6,
    parameter int IO_IDX  = 4,
    parameter int MEM_IDX = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [31:0]       cfg_rdata,
    input logic              frame_start,
    input logic              cmd_io_en,
    input logic              cmd_mem_en,
    input logic              dec_hit,
    input logic              dec_mem
);

    logic frame_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frame_seen <= 1'b0;
        else        frame_seen <= frame_start;
    end

    AST_IO_LOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == CFG_AW'(IO_IDX)) |-> (cfg_rdata[4:0] == 5'b00001)); // R1
    AST_MEM_LOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == CFG_AW'(MEM_IDX)) |-> (cfg_rdata[4:0] == 5'b00000)); // R2
    AST_IO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit && !dec_mem) |-> $past(cmd_io_en)); // R7
    AST_MEM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        dec_mem |-> ($past(cmd_mem_en) && dec_hit)); // R8
    AST_HIT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> ($past(frame_start) && !$past(frame_seen))); // R10
    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |=> !dec_hit); // R10

endmodule

bind pci_bar_decoder bar_dec_chk #(
    .CFG_AW  (CFG_AW),
    .IO_IDX  (IO_BAR_IDX),
    .MEM_IDX (MEM_BAR_IDX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_addr    (cfg_addr),
    .cfg_rdata   (cfg_rdata),
    .frame_start (frame_start),
    .cmd_io_en   (cmd_io_en),
    .cmd_mem_en  (cmd_mem_en),
    .dec_hit     (dec_hit),
    .dec_mem     (dec_mem)
);

// File: tb/sim_pci_bar_decoder.sv
`timescale 1ns/1ps
module sim_pci_bar_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] ad = '0;
    logic [3:0]  bus_cmd = '0;
    logic        frame_start = 1'b0;
    logic        cmd_io_en = 1'b0;
    logic        cmd_mem_en = 1'b0;
    logic        dec_hit, dec_mem;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] io_m  = 32'h0;
    logic [31:0] mem_m = 32'h0;

    always #2 clk = ~clk;

    pci_bar_decoder u0 (.*);

    function automatic logic [31:0] exp_read(input logic [5:0] idx);
        if (idx == 6'd4) return {io_m[31:5], 5'b00001};
        if (idx == 6'd5) return {mem_m[31:5], 5'b00000};
        return 32'h0;
    endfunction

    function automatic logic [1:0] exp_dec(input logic [31:0] a, input logic [3:0] c,
                                           input logic ioe, input logic meme);
        logic io_ok, mem_ok;
        io_ok  = (c == 4'h2 || c == 4'h3) && ioe && (a[31:5] == io_m[31:5]);
        mem_ok = (c == 4'h6 || c == 4'h7 || c == 4'hC || c == 4'hE) && meme
                 && (a[31:5] == mem_m[31:5]);
        return {io_ok || mem_ok, mem_ok};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] m;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = idx; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}} & 32'hFFFF_FFE0;
        if (idx == 6'd4) io_m  = (io_m & ~m) | (d & m);
        if (idx == 6'd5) mem_m = (mem_m & ~m) | (d & m);
    endtask

    task automatic read_chk(input logic [5:0] idx, input string tag);
        @(negedge clk);
        cfg_addr = idx;
        #1 check(tag, cfg_rdata, exp_read(idx));
    endtask

    task automatic decode(input logic [31:0] a, input logic [3:0] c, input logic ioe,
                          input logic meme, input int hold, input string tag);
        logic [1:0] e;
        e = exp_dec(a, c, ioe, meme);
        @(negedge clk);
        frame_start = 1'b1; ad = a; bus_cmd = c; cmd_io_en = ioe; cmd_mem_en = meme;
        @(posedge clk); #1;
        check({tag, " hit"}, {31'h0, dec_hit}, {31'h0, e[1]});
        check({tag, " mem"}, {31'h0, dec_mem}, {31'h0, e[0]});
        for (int k = 0; k < hold; k++) begin
            @(posedge clk); #1;
            check("R10 held frame no rehit", {31'h0, dec_hit}, 32'h0);
        end
        @(negedge clk);
        frame_start = 1'b0;
        @(posedge clk); #1;
        check("R10 pulse one cycle", {31'h0, dec_hit}, 32'h0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R6 reset state
        read_chk(6'd4, "R6 io reset");
        read_chk(6'd5, "R6 mem reset");
        check("R10 reset hit", {31'h0, dec_hit}, 32'h0);
        // R3 sizing probe
        cfg_write(6'd4, 4'hF, 32'hFFFF_FFFF);
        cfg_write(6'd5, 4'hF, 32'hFFFF_FFFF);
        check("R3 io size", exp_read(6'd4), 32'hFFFF_FFE1);
        read_chk(6'd4, "R3 io size read");
        read_chk(6'd5, "R3 mem size read");
        // R1 R2 low bits ignore writes
        cfg_write(6'd4, 4'hF, 32'h1234_561E);
        read_chk(6'd4, "R1 io base and low bits");
        cfg_write(6'd5, 4'hF, 32'hABCD_EF1F);
        read_chk(6'd5, "R2 mem base and low bits");
        // R4 byte lanes
        cfg_write(6'd4, 4'b0101, 32'h0000_0000);
        read_chk(6'd4, "R4 io partial lanes");
        cfg_write(6'd5, 4'b1000, 32'h5500_0000);
        read_chk(6'd5, "R4 mem top lane");
        // R5 other indices
        cfg_write(6'd6, 4'hF, 32'hFFFF_FFFF);
        cfg_write(6'd3, 4'hF, 32'h0000_0000);
        read_chk(6'd6, "R5 other index reads zero");
        read_chk(6'd4, "R5 io untouched");
        read_chk(6'd5, "R5 mem untouched");
        // R7 R8 R9 directed
        decode({io_m[31:5], 5'h1F}, 4'h2, 1'b1, 1'b0, 0, "R7 io read hit");
        decode({io_m[31:5], 5'h00}, 4'h3, 1'b1, 1'b1, 0, "R7 io write hit");
        decode({io_m[31:5], 5'h00}, 4'h3, 1'b0, 1'b1, 0, "R9 io disabled");
        decode({io_m[31:5] ^ 27'h1, 5'h0}, 4'h2, 1'b1, 1'b1, 0, "R7 io bit5 miss");
        decode({mem_m[31:5], 5'h04}, 4'h6, 1'b0, 1'b1, 0, "R8 mem read hit");
        decode({mem_m[31:5], 5'h04}, 4'hC, 1'b0, 1'b1, 0, "R8 mem read multiple");
        decode({mem_m[31:5], 5'h04}, 4'hE, 1'b1, 1'b1, 0, "R8 mem read line");
        decode({mem_m[31:5], 5'h04}, 4'h7, 1'b1, 1'b0, 0, "R9 mem disabled");
        decode({mem_m[31:5], 5'h04}, 4'hF, 1'b1, 1'b1, 0, "R9 other command");
        decode({io_m[31:5], 5'h04}, 4'h6, 1'b1, 1'b1, 0, "R9 mem cmd at io base");
        decode({mem_m[31:5], 5'h0}, 4'h7, 1'b0, 1'b1, 3, "R10 held frame");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [3:0]  c;
            logic [31:0] a;
            int          sel;
            sel = $urandom_range(0, 3);
            if (sel == 0) begin
                cfg_write(6'($urandom_range(3, 6)), 4'($urandom), $urandom);
                read_chk(6'($urandom_range(3, 6)), "R4 random read");
            end else begin
                c = 4'($urandom);
                a = $urandom;
                if (sel == 1) a[31:5] = io_m[31:5];
                if (sel == 2) a[31:5] = mem_m[31:5];
                decode(a, c, 1'($urandom), 1'($urandom), 0, "R9 random decode");
            end
        end
        // R6 hard reset clears
        @(negedge clk) rst_n = 1'b0;
        io_m = 32'h0; mem_m = 32'h0;
        @(negedge clk) rst_n = 1'b1;
        read_chk(6'd4, "R6 io cleared");
        read_chk(6'd5, "R6 mem cleared");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule